// File: doc/BRIEF.md
# Indirect Register Window Interface

This block is the software-facing front end of an interrupt redirection unit. A bus master sees only two registers: an 8-bit select register and a 32-bit data window. The value held in the select register decides what a window access reaches: an identification register, a read-only version word, an arbitration register that mirrors the identification value, or one half of a 64-bit redirection entry. Each entry occupies two adjacent select values, even for the low word and odd for the high word.

The whole redirection table is driven out in parallel to a delivery engine. After every accepted entry write, a one-cycle strobe carrying the entry index tells that engine to run a servicing pass. The delivery engine owns the per-entry "remote pending" bit. The block only reflects that bit in reads and in the table it drives, and never stores it from a bus write.

Top module: `irw_regwin`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Writes to any other offset change nothing, and reads of any other offset return 0.
- R2: A window access whose size is not 4 bytes is ignored. Such a read returns 0 and such a write changes nothing.
- R3: The select register is 8 bits wide and accepts any access size. A write stores wdata[7:0], and a read returns the stored value zero-extended.
- R4: With select 0x00, a window write stores wdata[27:24] as the 4-bit ID. Window reads with select 0x00 or select 0x02 return the ID in bits [27:24] with every other bit 0.
- R5: With select 0x01, a window read returns 0x11 | ((NPINS-1) << 16), which is 0x00170011 for 24 entries. Window writes with select 0x01 or 0x02 are ignored.
- R6: With select value s ≥ 0x10, the entry index is (s − 0x10) >> 1. An even s reaches bits [31:0] of the entry and an odd s reaches bits [63:32].
- R7: A write to one half of an entry leaves the other half of that entry and all other entries unchanged.
- R8: After an in-range entry write, svc_strobe is high for exactly the next cycle and svc_index gives the entry index. The new entry value appears on tbl_flat in that same cycle. No other access raises the strobe.
- R9: A select value below 0x10 other than 0x00–0x02, or a computed entry index ≥ NPINS, reads 0. Writes with such a select value change nothing.
- R10: Bit 14 of each entry's low word is the remote-pending bit. Reads and tbl_flat show it from input remote_irr[index], and a bus write never stores it.
- R11: After reset, the select register and ID are 0, bus_rdata and svc_strobe are 0, and every entry is 0x0000_0000_0001_0000, which has only the mask bit (bit 16) set.
- R12: Read data is registered. bus_rdata holds the read value in the cycle after the read request and is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W (12) | Byte address; only bits [7:0] are decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remote_irr | input | NPINS (24) | Remote-pending bit per entry, from the delivery engine |
| tbl_flat | output | NPINS*64 | Redirection table; entry n occupies bits [64n+63:64n] |
| svc_strobe | output | 1 | One-cycle request for a servicing pass |
| svc_index | output | IDX_W (5) | Index of the entry whose write raised the strobe |

## Verification
A corrupted select register does not show at the ports until the next window access. At that access the wrong register is reached, so one read after a select write exposes the fault, and a read of the select register shows it directly. A wrong stored ID or entry half shows on the following read with the matching select value. Entry faults also show at once on tbl_flat, and the strobe and index are checked in the cycle right after the write. A remote-pending bit that was latched from a write instead of taken from the input only shows after remote_irr changes, so the bench drives that input both ways around a low-word write.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 64;
  localparam logic [2:0]  FULL_SIZE = 3'd4;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_TBL
  } rd_src_e;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned NPINS  = 24,
  parameter int unsigned IDX_W  = 5,
  parameter logic [7:0]  OFF_SEL = 8'h00,
  parameter logic [7:0]  OFF_WIN = 8'h10,
  parameter logic [SEL_W-1:0] REG_ID  = 8'h00,
  parameter logic [SEL_W-1:0] REG_VER = 8'h01,
  parameter logic [SEL_W-1:0] REG_ARB = 8'h02,
  parameter logic [SEL_W-1:0] TBL_BASE = 8'h10
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [SEL_W-1:0]  sel_q,
  output logic              hit_sel,
  output logic              hit_win,
  output logic              is_id,
  output logic              is_idrd,
  output logic              is_ver,
  output logic              tbl_ok,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_hi
);
  localparam logic [SEL_W-2:0] NP_LIM = (SEL_W-1)'(NPINS);

  logic [7:0]       off;
  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] ent;
  logic             unused_addr;

  assign off         = bus_addr[7:0];
  assign unused_addr = ^bus_addr[ADDR_W-1:8];

  always_comb begin
    hit_sel = (off == OFF_SEL);
    hit_win = (off == OFF_WIN) && (bus_size == FULL_SIZE);
    is_id   = (sel_q == REG_ID);
    is_idrd = (sel_q == REG_ID) || (sel_q == REG_ARB);
    is_ver  = (sel_q == REG_VER);
    rel     = sel_q - TBL_BASE;
    ent     = rel[SEL_W-1:1];
    tbl_hi  = rel[0];
    tbl_ok  = (sel_q >= TBL_BASE) && (ent < NP_LIM);
    tbl_idx = ent[IDX_W-1:0];
  end
endmodule

// File: rtl/irw_table.sv
module irw_table
  import irw_pkg::*;
#(
  parameter int unsigned NPINS    = 24,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned RIRR_BIT = 14,
  parameter int unsigned MASK_BIT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     hi,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [NPINS-1:0]         remote_irr,
  output logic [WORD_W-1:0]        rd_word,
  output logic [NPINS*ENTRY_W-1:0] tbl_flat
);
  localparam logic [ENTRY_W-1:0] RST_ENT = ENTRY_W'(1) << MASK_BIT;
  localparam logic [ENTRY_W-1:0] RB_MSK  = ENTRY_W'(1) << RIRR_BIT;

  logic [ENTRY_W-1:0] view [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    logic [ENTRY_W-1:0] ent_d;
    logic               hit;

    assign hit = we && (idx == IDX_W'(g));

    always_comb begin
      ent_d = ent_q;
      if (hit) begin
        if (hi) begin
          ent_d[ENTRY_W-1:WORD_W] = wdata;
        end else begin
          ent_d[WORD_W-1:0] = wdata;
          ent_d[RIRR_BIT]   = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= RST_ENT;
      end else if (hit) begin
        ent_q <= ent_d;
      end
    end

    assign view[g] = (ent_q & ~RB_MSK) | (ENTRY_W'(remote_irr[g]) << RIRR_BIT);
    assign tbl_flat[g*ENTRY_W +: ENTRY_W] = view[g];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_word = hi ? view[i][ENTRY_W-1:WORD_W] : view[i][WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
#(
  parameter int unsigned NPINS      = 24,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned ID_LSB     = 24,
  parameter logic [7:0]  VER_CONST  = 8'h11,
  parameter int unsigned MAXENT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              hit_sel,
  input  logic              hit_win,
  input  logic              is_id,
  input  logic              is_idrd,
  input  logic              is_ver,
  input  logic              tbl_ok,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [WORD_W-1:0] tbl_rd,
  output logic              tbl_we,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ID_W-1:0]   id_q,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              svc_strobe,
  output logic [IDX_W-1:0]  svc_index
);
  localparam logic [WORD_W-1:0] VER_WORD =
    WORD_W'(VER_CONST) | (WORD_W'(NPINS - 1) << MAXENT_LSB);

  logic              wr_sel;
  logic              wr_win;
  logic [SEL_W-1:0]  sel_d;
  logic [ID_W-1:0]   id_d;
  logic [WORD_W-1:0] rdata_d;
  logic [IDX_W-1:0]  sidx_d;
  rd_src_e           src;
  logic              unused_wd;

  assign unused_wd = ^bus_wdata;

  always_comb begin
    wr_sel = bus_wr && hit_sel;
    wr_win = bus_wr && hit_win;
    tbl_we = wr_win && tbl_ok;
    sel_d  = wr_sel ? bus_wdata[SEL_W-1:0] : sel_q;
    id_d   = (wr_win && is_id) ? bus_wdata[ID_LSB +: ID_W] : id_q;
    sidx_d = tbl_we ? tbl_idx : svc_index;
  end

  always_comb begin
    src = SRC_NONE;
    if (bus_rd) begin
      if (hit_sel)                 src = SRC_SEL;
      else if (hit_win && is_idrd) src = SRC_ID;
      else if (hit_win && is_ver)  src = SRC_VER;
      else if (hit_win && tbl_ok)  src = SRC_TBL;
    end
    unique case (src)
      SRC_SEL: rdata_d = WORD_W'(sel_q);
      SRC_ID:  rdata_d = WORD_W'(id_q) << ID_LSB;
      SRC_VER: rdata_d = VER_WORD;
      SRC_TBL: rdata_d = tbl_rd;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      bus_rdata  <= '0;
      svc_strobe <= 1'b0;
      svc_index  <= '0;
    end else begin
      sel_q      <= sel_d;
      id_q       <= id_d;
      bus_rdata  <= rdata_d;
      svc_strobe <= tbl_we;
      svc_index  <= sidx_d;
    end
  end
endmodule

// File: rtl/irw_regwin.sv
module irw_regwin
  import irw_pkg::*;
#(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IDX_W  = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [2:0]               bus_size,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [NPINS-1:0]         remote_irr,
  output logic [NPINS*ENTRY_W-1:0] tbl_flat,
  output logic                     svc_strobe,
  output logic [IDX_W-1:0]         svc_index
);
  localparam int unsigned SEL_W = 8;
  localparam int unsigned ID_W  = 4;

  logic              hit_sel, hit_win, is_id, is_idrd, is_ver, tbl_ok, tbl_hi, tbl_we;
  logic [IDX_W-1:0]  tbl_idx;
  logic [SEL_W-1:0]  sel_q;
  logic [ID_W-1:0]   id_q;
  logic [WORD_W-1:0] tbl_rd;

  irw_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NPINS(NPINS), .IDX_W(IDX_W)
  ) u_dec (
    .bus_addr(bus_addr), .bus_size(bus_size), .sel_q(sel_q),
    .hit_sel(hit_sel), .hit_win(hit_win), .is_id(is_id), .is_idrd(is_idrd),
    .is_ver(is_ver), .tbl_ok(tbl_ok), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi)
  );

  irw_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(tbl_idx), .hi(tbl_hi),
    .wdata(bus_wdata), .remote_irr(remote_irr), .rd_word(tbl_rd),
    .tbl_flat(tbl_flat)
  );

  irw_ctrl #(.NPINS(NPINS), .IDX_W(IDX_W), .SEL_W(SEL_W), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .hit_sel(hit_sel), .hit_win(hit_win),
    .is_id(is_id), .is_idrd(is_idrd), .is_ver(is_ver), .tbl_ok(tbl_ok),
    .tbl_idx(tbl_idx), .tbl_rd(tbl_rd), .tbl_we(tbl_we), .sel_q(sel_q),
    .id_q(id_q), .bus_rdata(bus_rdata), .svc_strobe(svc_strobe),
    .svc_index(svc_index)
  );
endmodule

// File: rtl/irw_chk.sv
module irw_chk #(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              svc_strobe,
  input logic [7:0]        sel_q,
  input logic [3:0]        id_q
);
  localparam logic [31:0] VER_WORD = 32'h11 | (32'(NPINS - 1) << 16);

  logic win4;
  logic unused_chk;
  assign win4 = (bus_addr[7:0] == 8'h10) && (bus_size == 3'd4);
  assign unused_chk = ^bus_addr;

  p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_strobe |-> $past(bus_wr && win4 && sel_q >= 8'h10));

  p_badsize_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr[7:0] == 8'h10 && bus_size != 3'd4) |-> bus_rdata == 32'h0);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> bus_rdata == 32'h0);

  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && win4 && sel_q == 8'h00) |=> $stable(id_q));

  p_ver_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && win4 && sel_q == 8'h01) |-> bus_rdata == VER_WORD);

  p_sel_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr[7:0] == 8'h00) |-> sel_q == $past(bus_wdata[7:0]));
endmodule

bind irw_regwin irw_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .svc_strobe(svc_strobe), .sel_q(sel_q), .id_q(id_q)
);

// File: tb/sim_irw_regwin.sv
module sim_irw_regwin;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [2:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] remote_irr;
  logic [NP*64-1:0] tbl_flat;
  logic svc_strobe;
  logic [4:0] svc_index;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irw_regwin u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .remote_irr(remote_irr), .tbl_flat(tbl_flat),
    .svc_strobe(svc_strobe), .svc_index(svc_index)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic [11:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  1'b0, 12'h000, 3'd4, 32'h0000_0000},  // R3 select 0
    '{4'd4,  1'b0, 12'h010, 3'd4, 32'hA500_0000},  // R4 ID write
    '{4'd4,  1'b1, 12'h010, 3'd4, 32'h0500_0000},  // R4 ID read
    '{4'd4,  1'b0, 12'h000, 3'd4, 32'h0000_0002},
    '{4'd4,  1'b1, 12'h010, 3'd4, 32'h0500_0000},  // R4 arb alias
    '{4'd5,  1'b0, 12'h010, 3'd4, 32'hFFFF_FFFF},  // R5 arb write ignored
    '{4'd5,  1'b1, 12'h010, 3'd4, 32'h0500_0000},
    '{4'd3,  1'b0, 12'h000, 3'd1, 32'h0000_0001},  // R3 any size
    '{4'd3,  1'b1, 12'h000, 3'd4, 32'h0000_0001},
    '{4'd5,  1'b1, 12'h010, 3'd4, 32'h0017_0011},  // R5 version
    '{4'd5,  1'b0, 12'h010, 3'd4, 32'h1234_5678},
    '{4'd5,  1'b1, 12'h010, 3'd4, 32'h0017_0011},
    '{4'd6,  1'b0, 12'h000, 3'd4, 32'h0000_0010},
    '{4'd10, 1'b0, 12'h010, 3'd4, 32'h0000_40AB},  // R10 bit 14 not stored
    '{4'd10, 1'b1, 12'h010, 3'd4, 32'h0000_00AB},
    '{4'd6,  1'b0, 12'h000, 3'd4, 32'h0000_0011},
    '{4'd7,  1'b0, 12'h010, 3'd4, 32'hDEAD_BEEF},  // R7 upper half
    '{4'd7,  1'b1, 12'h010, 3'd4, 32'hDEAD_BEEF},
    '{4'd7,  1'b0, 12'h000, 3'd4, 32'h0000_0010},
    '{4'd7,  1'b1, 12'h010, 3'd4, 32'h0000_00AB},  // R7 lower kept
    '{4'd2,  1'b0, 12'h010, 3'd2, 32'h0000_1234},  // R2 short write
    '{4'd2,  1'b1, 12'h010, 3'd2, 32'h0000_0000},  // R2 short read
    '{4'd2,  1'b1, 12'h010, 3'd4, 32'h0000_00AB},
    '{4'd1,  1'b1, 12'h310, 3'd4, 32'h0000_00AB},  // R1 high bits ignored
    '{4'd1,  1'b0, 12'h004, 3'd4, 32'h0000_0077},  // R1 other offset
    '{4'd1,  1'b1, 12'h004, 3'd4, 32'h0000_0000},
    '{4'd1,  1'b1, 12'h000, 3'd4, 32'h0000_0010},
    '{4'd6,  1'b0, 12'h000, 3'd4, 32'h0000_003F},  // R6 last entry high
    '{4'd6,  1'b0, 12'h010, 3'd4, 32'hCAFE_F00D},
    '{4'd6,  1'b1, 12'h010, 3'd4, 32'hCAFE_F00D},
    '{4'd11, 1'b0, 12'h000, 3'd4, 32'h0000_003E},
    '{4'd11, 1'b1, 12'h010, 3'd4, 32'h0001_0000},  // R11 reset entry
    '{4'd9,  1'b0, 12'h000, 3'd4, 32'h0000_0040},  // R9 index 24
    '{4'd9,  1'b0, 12'h010, 3'd4, 32'hFFFF_FFFF},
    '{4'd9,  1'b1, 12'h010, 3'd4, 32'h0000_0000},
    '{4'd9,  1'b0, 12'h000, 3'd4, 32'h0000_000F},  // R9 unused select
    '{4'd9,  1'b1, 12'h010, 3'd4, 32'h0000_0000},
    '{4'd6,  1'b0, 12'h000, 3'd4, 32'h0000_0012},
    '{4'd6,  1'b1, 12'h010, 3'd4, 32'h0001_0000},
    '{4'd9,  1'b0, 12'h000, 3'd4, 32'h0000_003F},
    '{4'd9,  1'b1, 12'h010, 3'd4, 32'hCAFE_F00D}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic rd, input logic [11:0] a, input logic [2:0] sz,
                       input logic [31:0] d);
    @(negedge clk);
    bus_wr = !rd;
    bus_rd = rd;
    bus_addr = a;
    bus_size = sz;
    bus_wdata = rd ? 32'h0 : d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    remote_irr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 rdata", 64'(bus_rdata), 64'h0);
    check("R11 strobe", 64'(svc_strobe), 64'h0);
    check("R11 entry0", tbl_flat[63:0], 64'h0000_0000_0001_0000);
    check("R11 entry23", tbl_flat[23*64 +: 64], 64'h0000_0000_0001_0000);
    do_op(1'b1, 12'h000, 3'd4, 0);
    check("R11 select", 64'(bus_rdata), 64'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].rd, VEC[i].addr, VEC[i].size, VEC[i].data);
      if (VEC[i].rd) begin
        checks++;
        if (bus_rdata !== VEC[i].data) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[i].req, i, bus_rdata, VEC[i].data);
        end
      end
    end

    // R12 idle cycle after a read
    do_op(1'b1, 12'h010, 3'd4, 0);
    check("R12 read value", 64'(bus_rdata), 64'hCAFE_F00D);
    @(negedge clk);
    check("R12 idle zero", 64'(bus_rdata), 64'h0);

    // R8 strobe and index with same-cycle table update
    do_op(1'b0, 12'h000, 3'd4, 32'h15);
    check("R8 no strobe on select write", 64'(svc_strobe), 64'h0);
    do_op(1'b0, 12'h010, 3'd4, 32'h0000_0055);
    check("R8 strobe", 64'(svc_strobe), 64'h1);
    check("R8 index", 64'(svc_index), 64'h2);
    check("R8 table same cycle", 64'(tbl_flat[2*64+32 +: 32]), 64'h55);
    @(negedge clk);
    check("R8 strobe one cycle", 64'(svc_strobe), 64'h0);
    do_op(1'b0, 12'h000, 3'd4, 32'h00);
    do_op(1'b0, 12'h010, 3'd4, 32'h0300_0000);
    check("R8 no strobe on ID write", 64'(svc_strobe), 64'h0);
    do_op(1'b0, 12'h000, 3'd4, 32'h40);
    do_op(1'b0, 12'h010, 3'd4, 32'h1);
    check("R8 no strobe out of range", 64'(svc_strobe), 64'h0);

    // R10 remote bit from input only
    remote_irr[0] = 1'b1;
    do_op(1'b0, 12'h000, 3'd4, 32'h10);
    do_op(1'b1, 12'h010, 3'd4, 0);
    check("R10 reflect in read", 64'(bus_rdata), 64'h0000_40AB);
    check("R10 reflect in table", 64'(tbl_flat[14]), 64'h1);
    do_op(1'b0, 12'h010, 3'd4, 32'h0000_4000);
    remote_irr[0] = 1'b0;
    do_op(1'b1, 12'h010, 3'd4, 0);
    check("R10 write not stored", 64'(bus_rdata), 64'h0);
    check("R10 table cleared", 64'(tbl_flat[14]), 64'h0);
    remote_irr[0] = 1'b1;
    do_op(1'b1, 12'h010, 3'd4, 0);
    check("R10 reflect again", 64'(bus_rdata), 64'h0000_4000);

    summary();
  end
endmodule